// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter with Byte RAM

This block sits between a processor that time-shares one set of pins between address and data and a small static RAM. During the address phase, the processor raises an address strobe. The block captures the low address byte, the middle address byte and the top address nibble into strobe-controlled latches. The top nibble shares its pins with status information later in the cycle. The latched 20-bit address is presented on a buffered address bus. The latch is transparent while the strobe is high and holds its value once the strobe drops.

Data moves through a bidirectional byte transceiver. An active-low data enable turns the transceiver on, and a direction input chooses which way it drives. The RAM is 1024 bytes, built from two 4-bit-wide halves that are always selected together. It occupies a 1 KiB window set by a parameter. The RAM has no output enable of its own, so its active-low chip select is the OR of the window decode and the data enable. This keeps the RAM off the internal bus until the address has been captured and the processor has let go of the shared pins.

All storage is clocked by a system clock. The address latch adds a combinational bypass so that its output follows the pins while the strobe is high. A write takes place once, in the clock cycle where the write strobe falls.

Top module: `demux_ram`

## Requirements
- R1: While `ale` is 1, `laddr[7:0]` equals `ad_in`; after `ale` falls, it keeps the value sampled at the last rising clock edge with `ale` high, whatever `ad_in` does.
- R2: `laddr[19:16]` follows and holds `as_hi` under `ale` in the same way, so status values presented after the strobe falls do not reach the address.
- R3: `laddr[15:8]` follows and holds `a_mid` under `ale` in the same way.
- R4: `ad_oe` is 1 exactly when `den_n` is 0 and `dt_r` is 1 (transmit toward the processor). When `ad_oe` is 1, `ad_out` equals the internal data bus. Out of reset, `ad_oe`, `ram_drive` and `laddr` are 0.
- R5: Write data passes from `ad_in` to the RAM only in the receive direction (`den_n` 0, `dt_r` 0). A write strobe given while `dt_r` is 1 stores nothing.
- R6: `ram_cs_n` is 0 only when `den_n` is 0 and `laddr[19:10]` equals `BASE_ADDR[19:10]` (default base 0x04000).
- R7: A byte is stored at `laddr[9:0]` in the single clock cycle where `wr_n` goes from 1 to 0 with `ram_cs_n` at 0. Keeping `wr_n` low while `ad_in` changes does not overwrite it.
- R8: `ram_drive` is 1 exactly when `rd_n` is 0 and `ram_cs_n` is 0. `ram_q` is 0 when `ram_drive` is 0, and never non-zero while `den_n` is 1.
- R9: Both 4-bit halves are selected on every access. `ram_q[3:0]` comes from the low half and `ram_q[7:4]` from the high half, so a full byte is written or read in one access.
- R10: An access whose latched address is outside the window neither stores nor drives, and leaves the window's contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address strobe, latch transparent while 1 |
| den_n | input | 1 | Active-low data enable for transceiver and RAM select |
| dt_r | input | 1 | Transceiver direction: 1 toward processor, 0 toward memory |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Shared address/data pins as driven by the processor |
| a_mid | input | 8 | Middle address pins (bits 15..8) |
| as_hi | input | 4 | Shared top address / status pins (bits 19..16) |
| laddr | output | 20 | Latched, buffered address |
| ad_out | output | 8 | Transceiver drive toward the processor pins |
| ad_oe | output | 1 | Output enable for `ad_out` (0 means high impedance) |
| ram_cs_n | output | 1 | Gated active-low RAM chip select |
| ram_drive | output | 1 | RAM is driving the internal data bus |
| ram_q | output | 8 | RAM data onto the internal bus (0 when not driving) |

## Verification
Bytes with both halves differing (0x5A, 0xA5, 0x0F, 0xF0) and uniform bytes (0x00, 0xFF) are written and read back at the two ends of the window. These patterns expose swapped or missing halves and stuck bits. Every cycle, a status value is placed on the shared pins after the strobe drops. This tells a holding latch apart from one that stays transparent. A write strobe held low across a data change separates edge-triggered writes from level writes. Accesses just outside the window, and a write given in the transmit direction, separate a gated select from an ungated one. A per-clock model also checks that the RAM never drives while the data enable is inactive.

// File: rtl/demux_ram_pkg.sv
package demux_ram_pkg;
   localparam int ADDR_W  = 20;
   localparam int LOW_W   = 8;
   localparam int MID_W   = 8;
   localparam int HIGH_W  = ADDR_W - LOW_W - MID_W;
   localparam int DATA_W  = 8;

   typedef enum logic {
      DIR_TO_MEM = 1'b0,
      DIR_TO_CPU = 1'b1
   } xfer_dir_e;

   typedef struct packed {
      logic [HIGH_W-1:0] hi;
      logic [MID_W-1:0]  mid;
      logic [LOW_W-1:0]  lo;
   } bus_addr_t;
endpackage

// File: rtl/demux_addr_latch.sv
module demux_addr_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ale,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] held;

   initial begin
      if (W < 1) $error("demux_addr_latch: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held <= '0;
      else if (ale) held <= d;
   end

   // transparent while strobe high, frozen copy afterwards
   assign q = ale ? d : held;

   // R1/R2/R3: the stored copy never moves while the strobe is low
   p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |=> $stable(held));
endmodule

// File: rtl/demux_xcvr.sv
module demux_xcvr #(
   parameter int W = 8
) (
   input  logic         den_n,
   input  logic         dt_r,
   input  logic [W-1:0] cpu_in,
   input  logic [W-1:0] bus_in,
   output logic [W-1:0] cpu_out,
   output logic         cpu_oe,
   output logic [W-1:0] bus_out,
   output logic         bus_valid
);
   import demux_ram_pkg::*;

   xfer_dir_e dir;
   logic      en;

   assign dir       = xfer_dir_e'(dt_r);
   assign en        = ~den_n;
   assign cpu_oe    = en && (dir == DIR_TO_CPU);
   assign cpu_out   = cpu_oe ? bus_in : '0;
   assign bus_valid = en && (dir == DIR_TO_MEM);
   assign bus_out   = bus_valid ? cpu_in : '0;

   // R4: never both directions at once
   always_comb begin
      a_one_dir_r4: assert (!(cpu_oe && bus_valid));
   end
endmodule

// File: rtl/demux_ram_half.sv
module demux_ram_half #(
   parameter int AW = 10,
   parameter int W  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wd,
   input  logic          rd_en,
   output logic [W-1:0]  q
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] cells [DEPTH];

   initial begin
      if (AW < 1 || AW > 12) $error("demux_ram_half: AW out of range");
   end

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wd;
   end

   assign q = rd_en ? cells[addr] : '0;

   // R7: a write lasts a single cycle per strobe
   p_one_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);
endmodule

// File: rtl/demux_ram.sv
module demux_ram #(
   parameter int          RAM_AW    = 10,
   parameter int          HALF_W    = 4,
   parameter logic [19:0] BASE_ADDR = 20'h0_4000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ale,
   input  logic        den_n,
   input  logic        dt_r,
   input  logic        rd_n,
   input  logic        wr_n,
   input  logic [7:0]  ad_in,
   input  logic [7:0]  a_mid,
   input  logic [3:0]  as_hi,
   output logic [19:0] laddr,
   output logic [7:0]  ad_out,
   output logic        ad_oe,
   output logic        ram_cs_n,
   output logic        ram_drive,
   output logic [7:0]  ram_q
);
   import demux_ram_pkg::*;

   localparam int N_HALF = DATA_W / HALF_W;
   localparam int DEC_W  = ADDR_W - RAM_AW;

   initial begin
      if (DATA_W % HALF_W != 0) $error("demux_ram: HALF_W must divide DATA_W");
      if (RAM_AW >= ADDR_W)     $error("demux_ram: RAM_AW too large");
      if (BASE_ADDR[RAM_AW-1:0] != '0) $error("demux_ram: BASE_ADDR not window aligned");
   end

   // ---------------- address latches ----------------
   bus_addr_t lat;

   demux_addr_latch #(.W(LOW_W)) u_lat_lo (
      .clk(clk), .rst_n(rst_n), .ale(ale), .d(ad_in), .q(lat.lo));
   demux_addr_latch #(.W(MID_W)) u_lat_mid (
      .clk(clk), .rst_n(rst_n), .ale(ale), .d(a_mid), .q(lat.mid));
   demux_addr_latch #(.W(HIGH_W)) u_lat_hi (
      .clk(clk), .rst_n(rst_n), .ale(ale), .d(as_hi), .q(lat.hi));

   assign laddr = lat;

   // ---------------- decode and gated select ----------------
   logic dec_sel_n;
   assign dec_sel_n = (laddr[ADDR_W-1:RAM_AW] != BASE_ADDR[ADDR_W-1:RAM_AW]);
   assign ram_cs_n  = dec_sel_n | den_n;

   // ---------------- transceiver ----------------
   logic [DATA_W-1:0] wdata;
   logic              wvalid;

   demux_xcvr #(.W(DATA_W)) u_xcvr (
      .den_n(den_n), .dt_r(dt_r),
      .cpu_in(ad_in), .bus_in(ram_q),
      .cpu_out(ad_out), .cpu_oe(ad_oe),
      .bus_out(wdata), .bus_valid(wvalid));

   // ---------------- write strobe edge ----------------
   logic wr_q, we;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b1;
      else        wr_q <= wr_n;
   end
   assign we        = wr_q & ~wr_n & ~ram_cs_n & wvalid;
   assign ram_drive = ~rd_n & ~ram_cs_n;

   // ---------------- RAM halves ----------------
   for (genvar g = 0; g < N_HALF; g++) begin : g_half
      demux_ram_half #(.AW(RAM_AW), .W(HALF_W)) u_half (
         .clk(clk), .rst_n(rst_n), .we(we),
         .addr(laddr[RAM_AW-1:0]),
         .wd(wdata[g*HALF_W +: HALF_W]),
         .rd_en(ram_drive),
         .q(ram_q[g*HALF_W +: HALF_W]));
   end

   // ---------------- assertions ----------------
   p_cs_den_r6: assert property (@(posedge clk) disable iff (!rst_n)
      den_n |-> ram_cs_n);
   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      den_n |-> (!ram_drive && ram_q == '0));
   p_oe_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!den_n && dt_r));
   p_no_wr_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dt_r |-> !we);
   p_out_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (laddr[ADDR_W-1:RAM_AW] != BASE_ADDR[ADDR_W-1:RAM_AW]) |-> (!we && !ram_drive));
endmodule

// File: tb/demux_ram_bench.sv
module demux_ram_bench;
   localparam int PERIOD = 10;
   localparam logic [19:0] BASE = 20'h0_4000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ale = 0, den_n = 1, dt_r = 0, rd_n = 1, wr_n = 1;
   logic [7:0] ad_in = 8'h00, a_mid = 8'h00;
   logic [3:0] as_hi = 4'h0;
   logic [19:0] laddr;
   logic [7:0] ad_out, ram_q;
   logic ad_oe, ram_cs_n, ram_drive;

   int checks = 0, errors = 0;

   demux_ram #(.BASE_ADDR(BASE)) u_demux_ram (
      .clk(clk), .rst_n(rst_n), .ale(ale), .den_n(den_n), .dt_r(dt_r),
      .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .a_mid(a_mid), .as_hi(as_hi),
      .laddr(laddr), .ad_out(ad_out), .ad_oe(ad_oe), .ram_cs_n(ram_cs_n),
      .ram_drive(ram_drive), .ram_q(ram_q));

   always #(PERIOD/2) clk = ~clk;

   // ---------------- behavioural reference ----------------
   logic [19:0] lat_m;
   logic        wr_prev_m;
   logic [7:0]  mem_m [0:1023];
   logic [19:0] e_addr;
   logic        e_win, e_cs_n, e_drive, e_oe;
   logic [7:0]  e_q;

   always_comb begin
      e_addr  = ale ? {as_hi, a_mid, ad_in} : lat_m;
      e_win   = (e_addr[19:10] == BASE[19:10]);
      e_cs_n  = !(e_win && !den_n);
      e_drive = !rd_n && !e_cs_n;
      e_q     = e_drive ? mem_m[e_addr[9:0]] : 8'h00;
      e_oe    = !den_n && dt_r;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         lat_m     <= '0;
         wr_prev_m <= 1'b1;
      end else begin
         if (ale) lat_m <= {as_hi, a_mid, ad_in};
         if (wr_prev_m && !wr_n && !e_cs_n && !dt_r) mem_m[e_addr[9:0]] <= ad_in;
         wr_prev_m <= wr_n;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(laddr[7:0] === e_addr[7:0], "R1 low latch", laddr[7:0], e_addr[7:0]);
         chk(laddr[19:16] === e_addr[19:16], "R2 top latch", laddr[19:16], e_addr[19:16]);
         chk(laddr[15:8] === e_addr[15:8], "R3 mid latch", laddr[15:8], e_addr[15:8]);
         chk(ad_oe === e_oe, "R4 oe", ad_oe, e_oe);
         chk(ram_cs_n === e_cs_n, "R6 cs", ram_cs_n, e_cs_n);
         chk(ram_drive === e_drive, "R8 drive", ram_drive, e_drive);
         chk(ram_q === e_q, "R9 ram data", ram_q, e_q);
         if (ad_oe) chk(ad_out === e_q, "R4 out", ad_out, e_q);
         // single driver on the shared pins: the processor drives only when ad_oe is 0
         chk(!(ad_oe && !dt_r), "R4 one driver", ad_oe, 0);
      end
   end

   // ---------------- bus cycles ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic addr_phase(input logic [19:0] a);
      step();
      ale = 1; den_n = 1; rd_n = 1; wr_n = 1;
      ad_in = a[7:0]; a_mid = a[15:8]; as_hi = a[19:16];
      @(negedge clk);
      chk(ram_cs_n === 1'b1, "R6 cs off before data enable", ram_cs_n, 1);
   endtask

   task automatic release_bus();
      step();
      den_n = 1; rd_n = 1; wr_n = 1; dt_r = 0; ad_in = 8'hC3; as_hi = 4'h9;
   endtask

   task automatic bus_write(input logic [19:0] a, input logic [7:0] d, input logic dir);
      addr_phase(a);
      step();
      ale = 0; as_hi = 4'h6; a_mid = 8'h3C; ad_in = d; dt_r = dir; den_n = 0; wr_n = 0;
      @(negedge clk);
      chk(laddr === a, "R1 R2 R3 address held in data phase", laddr, a);
      step();
      release_bus();
   endtask

   task automatic bus_read(input logic [19:0] a, output logic [7:0] d);
      addr_phase(a);
      step();
      ale = 0; as_hi = 4'hA; a_mid = 8'h81; ad_in = 8'h5F; dt_r = 1; den_n = 0; rd_n = 0;
      @(negedge clk);
      d = ad_out;
      chk(laddr === a, "R1 R2 R3 address held in read", laddr, a);
      step();
      release_bus();
   endtask

   initial begin
      fork
         begin
            #(PERIOD * 150000);
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      join_none
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      chk(laddr === 20'h0, "R4 reset laddr", laddr, 0);
      chk(ad_oe === 1'b0, "R4 reset oe", ad_oe, 0);
      chk(ram_drive === 1'b0, "R4 reset drive", ram_drive, 0);
      rst_n = 1;
      step();

      // R9 / R5: byte patterns at the window ends
      bus_write(BASE + 20'h000, 8'h5A, 1'b0);
      bus_write(BASE + 20'h3FF, 8'hA5, 1'b0);
      bus_write(BASE + 20'h001, 8'h0F, 1'b0);
      bus_write(BASE + 20'h002, 8'hF0, 1'b0);
      bus_write(BASE + 20'h003, 8'h00, 1'b0);
      bus_write(BASE + 20'h004, 8'hFF, 1'b0);
      bus_read(BASE + 20'h000, r); chk(r === 8'h5A, "R5 R9 readback 5A", r, 8'h5A);
      bus_read(BASE + 20'h3FF, r); chk(r === 8'hA5, "R9 readback A5", r, 8'hA5);
      bus_read(BASE + 20'h001, r); chk(r === 8'h0F, "R9 low half only", r, 8'h0F);
      bus_read(BASE + 20'h002, r); chk(r === 8'hF0, "R9 high half only", r, 8'hF0);
      bus_read(BASE + 20'h003, r); chk(r === 8'h00, "R9 zeros", r, 8'h00);
      bus_read(BASE + 20'h004, r); chk(r === 8'hFF, "R9 ones", r, 8'hFF);

      // R5: write in the transmit direction stores nothing
      bus_write(BASE + 20'h000, 8'h11, 1'b1);
      bus_read(BASE + 20'h000, r); chk(r === 8'h5A, "R5 tx-direction write ignored", r, 8'h5A);

      // R10: just above and just below the window
      bus_write(BASE + 20'h400, 8'h77, 1'b0);
      bus_write(BASE - 20'h001, 8'h66, 1'b0);
      bus_read(BASE + 20'h000, r); chk(r === 8'h5A, "R10 window unchanged", r, 8'h5A);
      bus_read(BASE + 20'h3FF, r); chk(r === 8'hA5, "R10 window top unchanged", r, 8'hA5);
      bus_read(BASE + 20'h400, r); chk(r === 8'h00, "R10 no drive outside", r, 8'h00);

      // R7: strobe held low while data changes
      addr_phase(BASE + 20'h123);
      step(); ale = 0; dt_r = 0; den_n = 0; wr_n = 0; ad_in = 8'h3E;
      step(); ad_in = 8'hD1;
      step(); ad_in = 8'h29;
      release_bus();
      bus_read(BASE + 20'h123, r); chk(r === 8'h3E, "R7 single write per strobe", r, 8'h3E);

      // R8: read strobe without data enable leaves RAM quiet
      addr_phase(BASE + 20'h123);
      step(); ale = 0; rd_n = 0; den_n = 1;
      @(negedge clk);
      chk(ram_drive === 1'b0, "R8 no drive without DEN", ram_drive, 0);
      chk(ram_q === 8'h00, "R8 ram_q zero without DEN", ram_q, 0);
      release_bus();

      repeat (3) step();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule